// File: doc/BRIEF.md
# I2C Receive Interrupt and Wait Controller

This block sits next to an I2C byte shifter and watches the SCL falling-edge strobe to count clock pulses inside each byte. It decides when the bus interrupt request is raised. The request always fires on the acknowledge clock, which is the clock after the last data bit. During data reception it can also fire one clock earlier, just before the acknowledge clock. Software uses that early point to choose the ACK or NACK value before the acknowledge clock is issued.

A request produces a one-cycle pulse and clears an active-low pending flag. It also asserts an SCL hold output, so the bus is stretched until software restarts the transfer. Software reads a wait flag to learn which of the two points fired, and so which restart action applies. If the wait flag is 1, the early point fired and software writes the ACK register. If it is 0, the acknowledge point fired and software writes the data register.

The mode encoding on `mode` is: 2'b00 transmit, 2'b01 slave-address receive, 2'b10 data receive. The value 2'b11 is handled like transmit. With the default of 8 data bits per byte, the early point is the 8th SCL fall after a byte start and the acknowledge point is the 9th.

Top module: `rx_irq_wait_ctrl`

## Requirements
- R1: After reset, `irqReq`=0, `pendingN`=1, `waitFlag`=0 and `sclHold`=0.
- R2: The 9th SCL fall after a byte start raises `irqReq` in every mode, whatever the enable bit holds. `irqReq` is high in the clock cycle after the strobe.
- R3: In data receive (`mode`=2'b10), with `ackClkEn`=1 and the early enable bit written to 1, the 8th SCL fall raises `irqReq`.
- R4: In transmit and address-receive modes, the 8th fall raises no request and `waitFlag` stays 0.
- R5: With `ackClkEn`=0, the enable bit counts as 0: the 8th fall raises no request and `waitFlag` stays 0.
- R6: Each request is a single-cycle `irqReq` pulse, and `pendingN` goes to 0 in the same cycle.
- R7: `waitFlag`, which is the value software reads in place of the enable bit, is 1 after an 8th-fall request and 0 after a 9th-fall request.
- R8: A write to the ACK register clears `waitFlag`, releases `sclHold` and sets `pendingN` to 1.
- R9: A write to the data register releases `sclHold` and sets `pendingN` to 1. In data receive with the enable in effect, it also sets `waitFlag` to 1.
- R10: `sclHold` is 1 whenever `pendingN` is 0.
- R11: `byteStartStb` restarts the fall count, so the 8th and 9th falls are counted from the most recent byte start.
- R12: A write to the pending register sets `pendingN` to 1 without releasing `sclHold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclFallStb | input | 1 | One-cycle strobe for each SCL falling edge |
| byteStartStb | input | 1 | One-cycle strobe at the start of a byte; clears the fall count |
| mode | input | 2 | 00 transmit, 01 address receive, 10 data receive |
| ackClkEn | input | 1 | 1 when an acknowledge clock is present |
| earlyEnWr | input | 1 | Write strobe for the early-interrupt enable bit |
| earlyEnWrData | input | 1 | Value written to the enable bit |
| ackRegWr | input | 1 | Write strobe for the ACK register (restart after the early point) |
| dataRegWr | input | 1 | Write strobe for the data register (restart after the acknowledge point) |
| pendRegWr | input | 1 | Write strobe that sets the pending flag back to 1 |
| irqReq | output | 1 | One-cycle interrupt request pulse |
| pendingN | output | 1 | 0 while a request is pending |
| waitFlag | output | 1 | Internal wait flag; the read value of the enable bit |
| sclHold | output | 1 | Stretches SCL until software restarts the transfer |

## Verification
The assertions check the following on every cycle:
- `sclHold` is high whenever `pendingN` is low.
- A request pulse always appears with a low `pendingN` and directly after an SCL fall strobe.
- `waitFlag` drops after the mode leaves data receive, after the acknowledge clock is disabled, or after an ACK register write.
- A restart write releases the hold.

Only the bench's scenarios show at which fall number each request fires, because that depends on the count since the last byte start. The same holds for the wait flag telling the two interrupt points apart, and for pending-register writes leaving the hold in place. The bench covers both through a sweep of every mode, acknowledge-clock setting and enable value.

// File: rtl/rxw_pkg.sv
`timescale 1ns/1ps
package rxw_pkg;

  typedef enum logic [1:0] {
    MODE_TX      = 2'b00,
    MODE_ADDR_RX = 2'b01,
    MODE_DATA_RX = 2'b10
  } rxwMode_e;

  // Strobes from the control decode to the datapath registers
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic raise;
    logic waitSet;
    logic waitClr;
    logic pendSet;
    logic restart;
  } ctlStrb_t;

endpackage

// File: rtl/rxw_ctrl.sv
`timescale 1ns/1ps
module rxw_ctrl
  import rxw_pkg::*;
#(
  parameter int BITS_PER_BYTE = 8,
  localparam int CNT_MAX = BITS_PER_BYTE + 1,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic [CNT_W-1:0] bitCount,
  input  logic             enReg,
  input  logic             sclFallStb,
  input  logic             byteStartStb,
  input  logic [1:0]       mode,
  input  logic             ackClkEn,
  input  logic             ackRegWr,
  input  logic             dataRegWr,
  input  logic             pendRegWr,
  output ctlStrb_t         ctl
);

  logic dataRx;
  logic effEn;
  logic fallLive;
  logic atEarly;
  logic atAck;
  logic earlyHit;

  always_comb begin
    dataRx   = (mode == MODE_DATA_RX);
    effEn    = ackClkEn & enReg;
    fallLive = sclFallStb & ~byteStartStb;
    atEarly  = fallLive & (bitCount == CNT_W'(BITS_PER_BYTE - 1));
    atAck    = fallLive & (bitCount == CNT_W'(BITS_PER_BYTE));
    earlyHit = atEarly & dataRx & effEn;

    ctl.cntClear = byteStartStb;
    ctl.cntInc   = fallLive & (bitCount != CNT_W'(CNT_MAX));
    ctl.raise    = earlyHit | atAck;
    ctl.waitClr  = ~dataRx | ~effEn | ackRegWr | atAck;
    ctl.waitSet  = earlyHit | (dataRegWr & dataRx & effEn);
    ctl.restart  = ackRegWr | dataRegWr;
    ctl.pendSet  = ackRegWr | dataRegWr | pendRegWr;
  end

endmodule

// File: rtl/rxw_datapath.sv
`timescale 1ns/1ps
module rxw_datapath
  import rxw_pkg::*;
#(
  parameter int BITS_PER_BYTE = 8,
  localparam int CNT_MAX = BITS_PER_BYTE + 1,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         ctl,
  input  logic             earlyEnWr,
  input  logic             earlyEnWrData,
  output logic [CNT_W-1:0] bitCount,
  output logic             enReg,
  output logic             irqReq,
  output logic             pendingN,
  output logic             waitFlag,
  output logic             sclHold
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (ctl.cntClear) begin
      bitCount <= '0;
    end else if (ctl.cntInc) begin
      bitCount <= bitCount + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= 1'b0;
    end else if (earlyEnWr) begin
      enReg <= earlyEnWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq   <= 1'b0;
      pendingN <= 1'b1;
      sclHold  <= 1'b0;
      waitFlag <= 1'b0;
    end else begin
      irqReq <= ctl.raise;

      if (ctl.raise) begin
        pendingN <= 1'b0;
      end else if (ctl.pendSet) begin
        pendingN <= 1'b1;
      end

      if (ctl.raise) begin
        sclHold <= 1'b1;
      end else if (ctl.restart) begin
        sclHold <= 1'b0;
      end

      if (ctl.waitClr) begin
        waitFlag <= 1'b0;
      end else if (ctl.waitSet) begin
        waitFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_irq_wait_ctrl.sv
`timescale 1ns/1ps
module rx_irq_wait_ctrl
  import rxw_pkg::*;
#(
  parameter int BITS_PER_BYTE = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclFallStb,
  input  logic       byteStartStb,
  input  logic [1:0] mode,
  input  logic       ackClkEn,
  input  logic       earlyEnWr,
  input  logic       earlyEnWrData,
  input  logic       ackRegWr,
  input  logic       dataRegWr,
  input  logic       pendRegWr,
  output logic       irqReq,
  output logic       pendingN,
  output logic       waitFlag,
  output logic       sclHold
);

  localparam int CNT_W = $clog2(BITS_PER_BYTE + 2);

  ctlStrb_t         ctl;
  logic [CNT_W-1:0] bitCount;
  logic             enReg;

  rxw_ctrl #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_ctrl (
    .bitCount     (bitCount),
    .enReg        (enReg),
    .sclFallStb   (sclFallStb),
    .byteStartStb (byteStartStb),
    .mode         (mode),
    .ackClkEn     (ackClkEn),
    .ackRegWr     (ackRegWr),
    .dataRegWr    (dataRegWr),
    .pendRegWr    (pendRegWr),
    .ctl          (ctl)
  );

  rxw_datapath #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .earlyEnWr     (earlyEnWr),
    .earlyEnWrData (earlyEnWrData),
    .bitCount      (bitCount),
    .enReg         (enReg),
    .irqReq        (irqReq),
    .pendingN      (pendingN),
    .waitFlag      (waitFlag),
    .sclHold       (sclHold)
  );

endmodule

// File: rtl/rx_irq_wait_ctrl_chk.sv
`timescale 1ns/1ps
module rx_irq_wait_ctrl_chk
  import rxw_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclFallStb,
  input logic [1:0] mode,
  input logic       ackClkEn,
  input logic       ackRegWr,
  input logic       dataRegWr,
  input logic       irqReq,
  input logic       pendingN,
  input logic       waitFlag,
  input logic       sclHold
);

  AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    !pendingN |-> sclHold); // R10

  AST_IRQ_LOWERS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !pendingN); // R6

  AST_IRQ_FROM_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(sclFallStb)); // R2

  AST_NO_WAIT_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_DATA_RX) |=> !waitFlag); // R4

  AST_NO_WAIT_WITHOUT_ACKCLK: assert property (@(posedge clk) disable iff (!rstN)
    !ackClkEn |=> !waitFlag); // R5

  AST_ACK_WRITE_CLEARS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    ackRegWr |=> !waitFlag); // R8

  AST_RESTART_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    ((ackRegWr || dataRegWr) && !sclFallStb) |=> (!sclHold && pendingN)); // R9

endmodule

bind rx_irq_wait_ctrl rx_irq_wait_ctrl_chk u_chk (.*);

// File: tb/rx_irq_wait_ctrl_bench.sv
`timescale 1ns/1ps
module rx_irq_wait_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclFallStb = 1'b0;
  logic       byteStartStb = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       ackClkEn = 1'b0;
  logic       earlyEnWr = 1'b0;
  logic       earlyEnWrData = 1'b0;
  logic       ackRegWr = 1'b0;
  logic       dataRegWr = 1'b0;
  logic       pendRegWr = 1'b0;
  logic       irqReq;
  logic       pendingN;
  logic       waitFlag;
  logic       sclHold;

  int  nChecks = 0;
  int  nFails = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  rx_irq_wait_ctrl u_rx_irq_wait_ctrl (
    .clk(clk), .rstN(rstN), .sclFallStb(sclFallStb), .byteStartStb(byteStartStb),
    .mode(mode), .ackClkEn(ackClkEn), .earlyEnWr(earlyEnWr),
    .earlyEnWrData(earlyEnWrData), .ackRegWr(ackRegWr), .dataRegWr(dataRegWr),
    .pendRegWr(pendRegWr), .irqReq(irqReq), .pendingN(pendingN),
    .waitFlag(waitFlag), .sclHold(sclHold)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input logic eIrq, input logic ePend,
                          input logic eWait, input logic eHold);
    chk(req, "irqReq", irqReq, eIrq);
    chk(req, "pendingN", pendingN, ePend);
    chk(req, "waitFlag", waitFlag, eWait);
    chk("R10", "sclHold", sclHold, eHold);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    @(negedge clk);
  endtask

  // Each strobe is driven for one cycle; the check follows at the next negedge
  task automatic pulseFall();
    @(negedge clk); sclFallStb = 1'b1;
    @(negedge clk); sclFallStb = 1'b0;
  endtask
  task automatic pulseByte();
    @(negedge clk); byteStartStb = 1'b1;
    @(negedge clk); byteStartStb = 1'b0;
  endtask
  task automatic pulseAck();
    @(negedge clk); ackRegWr = 1'b1;
    @(negedge clk); ackRegWr = 1'b0;
  endtask
  task automatic pulseData();
    @(negedge clk); dataRegWr = 1'b1;
    @(negedge clk); dataRegWr = 1'b0;
  endtask
  task automatic pulsePend();
    @(negedge clk); pendRegWr = 1'b1;
    @(negedge clk); pendRegWr = 1'b0;
  endtask
  task automatic writeEn(input logic v);
    @(negedge clk); earlyEnWr = 1'b1; earlyEnWrData = v;
    @(negedge clk); earlyEnWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset();
    checkAll("R1", 1'b0, 1'b1, 1'b0, 1'b0);

    // Sweep every mode, acknowledge-clock setting and enable value
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 2; a++) begin
        for (int e = 0; e < 2; e++) begin
          logic eff;
          string rEarly;
          eff = (m == 2) && (a == 1) && (e == 1);
          rEarly = (m != 2) ? "R4" : ((a == 0) ? "R5" : "R3");
          mode = 2'(m); ackClkEn = a[0];
          doReset();
          writeEn(e[0]);
          for (int b = 0; b < 2; b++) begin
            logic wPre;
            wPre = (b == 1) ? eff : 1'b0;
            pulseByte();
            for (int k = 1; k <= 7; k++) begin
              pulseFall();
              checkAll("R11", 1'b0, 1'b1, wPre, 1'b0);
            end
            pulseFall();                     // 8th fall
            if (eff) begin
              checkAll("R3", 1'b1, 1'b0, 1'b1, 1'b1);
              chk("R7", "waitFlag after early", waitFlag, 1'b1);
              @(negedge clk);
              chk("R6", "irqReq single cycle", irqReq, 1'b0);
              pulseAck();
              checkAll("R8", 1'b0, 1'b1, 1'b0, 1'b0);
            end else begin
              checkAll(rEarly, 1'b0, 1'b1, 1'b0, 1'b0);
            end
            pulseFall();                     // 9th fall
            checkAll("R2", 1'b1, 1'b0, 1'b0, 1'b1);
            chk("R7", "waitFlag after ack point", waitFlag, 1'b0);
            @(negedge clk);
            chk("R6", "irqReq single cycle", irqReq, 1'b0);
            if (b == 0) begin
              pulsePend();
              checkAll("R12", 1'b0, 1'b1, 1'b0, 1'b1);
            end
            pulseData();
            checkAll("R9", 1'b0, 1'b1, eff, 1'b0);
          end
        end
      end
    end

    // Byte start in the middle of a byte restarts the count
    mode = 2'b10; ackClkEn = 1'b1;
    doReset();
    writeEn(1'b1);
    pulseByte();
    for (int k = 1; k <= 5; k++) pulseFall();
    pulseByte();
    for (int k = 1; k <= 7; k++) begin
      pulseFall();
      chk("R11", "irqReq before 8th after restart", irqReq, 1'b0);
    end
    pulseFall();
    chk("R11", "irqReq on 8th after restart", irqReq, 1'b1);
    chk("R3", "waitFlag on 8th after restart", waitFlag, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule